// File: doc/BRIEF.md
# Cascadable Interval Down-Counter

This block is a 16-bit interval timer that decrements a counter and reloads it from a separately written reload register each time it runs out. The count source is chosen by a two-bit source field. It can count every system clock. It can count rising edges of an asynchronous input pin, which are first synchronised and turned into one-clock pulses. It can also count single-cycle pulses from a neighbouring timer, which lets two instances form one long interval. A run bit gates every count source.

The reload sequence depends on the source. When the block counts system clocks, the counter reloads directly from one instead of reaching zero, and one enable cycle is swallowed after the reload, so the reloaded value is shown for two clocks (3, 2, 1, 3, 3, 2). When the block counts pulses, zero is a real state that lasts until the next pulse (3, 2, 1, 0, 3, 2). The count enable passes through one pipeline register, so counting starts one clock after run goes high and stops one clock after run goes low.

A three-state controller holds the enable pipeline:

- **ST_IDLE**: no enable is pending.
- **ST_LIVE**: this edge counts or reloads.
- **ST_SKIP**: the edge swallowed after a reload in system-clock mode.

The controller has these transitions:

- ST_IDLE→ST_LIVE: a gated request is present.
- ST_LIVE→ST_LIVE: the request continues.
- ST_LIVE→ST_SKIP: a reload happens in system-clock mode.
- ST_LIVE→ST_IDLE: the request ends.
- ST_SKIP→ST_LIVE or ST_SKIP→ST_IDLE: chosen by the request.

Top module: `cascade_timer`

## Requirements
- R1: A synchronous active-high reset clears the counter, the reload register, the underflow output, the synchroniser stages and the controller state (ST_IDLE).
- R2: With src_mode = 0 (system clock) and run high, the counter decrements by one on every rising clock edge.
- R3: After run is sampled low, at most one further count or reload takes place (the one already in the pipeline). After that, count holds and underflow stays low for as long as run is low.
- R4: The first decrement after run rises happens on the second rising edge that samples run high. After the first edge the count is unchanged.
- R5: On a reload, count takes the value the reload register held before that edge, and underflow is high for exactly the one cycle in which the reloaded value first appears.
- R6: In system-clock mode, an enabled edge that sees count 1 (or 0) reloads instead of decrementing, and the following edge does not count, so zero is never shown: 3,2,1,3,3,2.
- R7: With src_mode = 1, each rising edge of the asynchronous pin ext_cnt causes exactly one count on the fourth rising clock edge after the pin rises, however long the pin stays high. Zero is shown and the next count reloads: 3,2,1,0,3.
- R8: With src_mode = 2 or 3, each cycle of chain_in high causes one count two edges later, with the same pass-through-zero reload as R7. Driving chain_in from another instance's underflow chains the two.
- R9: A write of latch_din (latch_we) changes only the reload register, never count. force_load copies the reload register's old value into count and takes priority over counting and reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_mode | input | 2 | Count source: 0 system clock, 1 pin edges, 2/3 chain pulses |
| run | input | 1 | Gates the count request |
| ext_cnt | input | 1 | Asynchronous external count pin |
| chain_in | input | 1 | Synchronous count pulse from a preceding timer |
| latch_we | input | 1 | Write strobe for the reload register |
| latch_din | input | 16 | Reload register write data |
| force_load | input | 1 | Copy reload register into the counter |
| count | output | 16 | Current counter value |
| underflow | output | 1 | One-cycle pulse in the cycle a reload appears |

## Verification
The bench follows the system-clock sequence across two reloads. A design that let zero through, or that did not skip the edge after a reload, would show 0 or a 3,2 step where 3,3 is expected. It holds the pin high for several clocks after each edge, so a synchroniser that gave a level instead of one pulse would count more than once. It also checks the exact edge of the first count, which catches a start-up delay of zero or two cycles. In the chained case, it checks the second timer's value on the edges around each underflow of the first, so a chain that skipped the enable register, or counted an extra time, would show an early or doubled decrement. Latch writes while stopped, and a stop issued in the middle of counting, check that nothing leaks past the run gate.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;
    typedef enum logic [1:0] {
        SRC_SYSCLK = 2'd0,
        SRC_PIN    = 2'd1,
        SRC_CHAIN  = 2'd2,
        SRC_CHAIN2 = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LIVE = 2'd1,
        ST_SKIP = 2'd2
    } tstate_e;
endpackage

// File: rtl/ctimer_edge_sync.sv
module ctimer_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_pulse
);
    localparam int TAPS = STAGES + 1;

    logic [TAPS-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[TAPS-2:0], async_in};
    end

    assign rise_pulse = shreg[STAGES-1] & ~shreg[STAGES];

    // R7: one clock-wide pulse per rising edge
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/ctimer_fsm.sv
module ctimer_fsm
    import ctimer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req,
    input  logic    reload_evt,
    input  logic    clk_mode,
    output tstate_e state,
    output logic    live
);
    tstate_e nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        unique case (state)
            ST_IDLE: nxt = req ? ST_LIVE : ST_IDLE;
            ST_LIVE: nxt = (reload_evt && clk_mode) ? ST_SKIP
                         : (req ? ST_LIVE : ST_IDLE);
            ST_SKIP: nxt = req ? ST_LIVE : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        live = (state == ST_LIVE);
    end

    // R6: the swallowed edge lasts exactly one cycle
    a_r6_skip_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |=> (state != ST_SKIP));
endmodule

// File: rtl/ctimer_counter.sv
module ctimer_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             live,
    input  logic             clk_mode,
    input  logic             latch_we,
    input  logic [WIDTH-1:0] latch_din,
    input  logic             force_load,
    output logic [WIDTH-1:0] count,
    output logic             underflow,
    output logic             reload_evt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] latch_q;
    logic             at_floor;

    assign at_floor   = (count == '0) || (clk_mode && (count == ONE));
    assign reload_evt = live && !force_load && at_floor;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q   <= '0;
            count     <= '0;
            underflow <= 1'b0;
        end else begin
            if (latch_we) latch_q <= latch_din;
            underflow <= reload_evt;
            if (force_load)      count <= latch_q;
            else if (reload_evt) count <= latch_q;
            else if (live)       count <= count - ONE;
        end
    end

    // R5: reloaded value is the reload register's prior content
    a_r5_reload_from_latch: assert property (@(posedge clk) disable iff (rst)
        underflow |-> (count == $past(latch_q)));

    // R9: without enable or force, latch writes leave count alone
    a_r9_latch_isolated: assert property (@(posedge clk) disable iff (rst)
        (!live && !force_load) |=> (count == $past(count)));
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
    import ctimer_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       src_mode,
    input  logic             run,
    input  logic             ext_cnt,
    input  logic             chain_in,
    input  logic             latch_we,
    input  logic [WIDTH-1:0] latch_din,
    input  logic             force_load,
    output logic [WIDTH-1:0] count,
    output logic             underflow
);
    logic    pin_rise;
    logic    src_req;
    logic    req;
    logic    clk_mode;
    logic    live;
    logic    reload_evt;
    tstate_e state;

    ctimer_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .async_in   (ext_cnt),
        .rise_pulse (pin_rise)
    );

    always_comb begin
        case (src_mode)
            SRC_SYSCLK: src_req = 1'b1;
            SRC_PIN:    src_req = pin_rise;
            default:    src_req = chain_in;
        endcase
    end

    assign clk_mode = (src_mode == SRC_SYSCLK);
    assign req      = src_req & run;

    ctimer_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .reload_evt (reload_evt),
        .clk_mode   (clk_mode),
        .state      (state),
        .live       (live)
    );

    ctimer_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .live       (live),
        .clk_mode   (clk_mode),
        .latch_we   (latch_we),
        .latch_din  (latch_din),
        .force_load (force_load),
        .count      (count),
        .underflow  (underflow),
        .reload_evt (reload_evt)
    );

    // R3: stopped and drained means frozen
    a_r3_stopped_holds: assert property (@(posedge clk) disable iff (rst)
        (!run && state != ST_LIVE && !force_load) |=> ($stable(count) && !underflow));

    // R6: the swallowed edge does not move the counter
    a_r6_skip_holds: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP && !force_load) |=> $stable(count));
endmodule

// File: tb/cascade_timer_test.sv
module cascade_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  a_mode = 2'd0, b_mode = 2'd2;
    logic        a_run = 1'b0, b_run = 1'b0;
    logic        a_pin = 1'b0;
    logic        a_we = 1'b0, b_we = 1'b0;
    logic [15:0] a_din = '0, b_din = '0;
    logic        a_force = 1'b0, b_force = 1'b0;
    logic [15:0] a_count, b_count;
    logic        a_uf, b_uf;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    cascade_timer uut (
        .clk(clk), .rst(rst), .src_mode(a_mode), .run(a_run), .ext_cnt(a_pin),
        .chain_in(1'b0), .latch_we(a_we), .latch_din(a_din), .force_load(a_force),
        .count(a_count), .underflow(a_uf)
    );

    cascade_timer uut_b (
        .clk(clk), .rst(rst), .src_mode(b_mode), .run(b_run), .ext_cnt(1'b0),
        .chain_in(a_uf), .latch_we(b_we), .latch_din(b_din), .force_load(b_force),
        .count(b_count), .underflow(b_uf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_a(input logic [15:0] v);
        a_din = v; a_we = 1'b1; step(1); a_we = 1'b0;
        a_force = 1'b1; step(1); a_force = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; step(2); rst = 1'b0; step(1);
        chk("R1 count after reset", 32'(a_count), 32'h0);
        chk("R1 underflow after reset", 32'(a_uf), 32'h0);
        chk("R1 chained count after reset", 32'(b_count), 32'h0);
    endtask

    task automatic t_clock_mode;
        logic [15:0] ev [9] = '{16'd3, 16'd2, 16'd1, 16'd3, 16'd3, 16'd2, 16'd1, 16'd3, 16'd3};
        logic        eu [9] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
        a_mode = 2'd0;
        load_a(16'd3);
        chk("R9 force_load value", 32'(a_count), 32'd3);
        a_run = 1'b1;
        for (int i = 0; i < 9; i++) begin
            step(1);
            chk("R2 R6 clock-mode count", 32'(a_count), 32'(ev[i]));
            chk("R5 clock-mode underflow", 32'(a_uf), 32'(eu[i]));
        end
        a_run = 1'b0; step(3);
    endtask

    task automatic t_stop;
        a_mode = 2'd0;
        load_a(16'd5);
        a_run = 1'b1;
        step(1); chk("R4 no count on first edge", 32'(a_count), 32'd5);
        step(1); chk("R4 count on second edge", 32'(a_count), 32'd4);
        step(1); chk("R2 steady decrement", 32'(a_count), 32'd3);
        a_run = 1'b0;
        step(1); chk("R3 one count in flight", 32'(a_count), 32'd2);
        a_din = 16'h1234; a_we = 1'b1; step(1); a_we = 1'b0;
        chk("R9 latch write leaves count", 32'(a_count), 32'd2);
        for (int i = 0; i < 4; i++) begin
            step(1);
            chk("R3 stopped count holds", 32'(a_count), 32'd2);
            chk("R3 no underflow when stopped", 32'(a_uf), 32'd0);
        end
        a_force = 1'b1; step(1); a_force = 1'b0;
        chk("R9 force_load takes new latch", 32'(a_count), 32'h1234);
    endtask

    task automatic t_pin_mode;
        logic [15:0] ev [4] = '{16'd2, 16'd1, 16'd0, 16'd3};
        logic [15:0] prev;
        a_mode = 2'd1; a_pin = 1'b0;
        load_a(16'd3);
        a_run = 1'b1;
        step(3);
        chk("R7 no pin edge no count", 32'(a_count), 32'd3);
        prev = 16'd3;
        for (int i = 0; i < 4; i++) begin
            a_pin = 1'b1;
            step(3);
            chk("R7 count not yet applied", 32'(a_count), 32'(prev));
            step(1);
            chk("R7 pin-edge count", 32'(a_count), 32'(ev[i]));
            chk("R5 pin-mode underflow", 32'(a_uf), (i == 3) ? 32'd1 : 32'd0);
            step(3);
            chk("R7 held pin counts once", 32'(a_count), 32'(ev[i]));
            a_pin = 1'b0;
            step(2);
            prev = ev[i];
        end
        a_run = 1'b0; step(2);
    endtask

    task automatic t_chain;
        logic [15:0] eb [11] = '{16'd2, 16'd2, 16'd2, 16'd2, 16'd1, 16'd1,
                                 16'd1, 16'd0, 16'd0, 16'd0, 16'd2};
        a_mode = 2'd0; b_mode = 2'd2;
        a_din = 16'd2; b_din = 16'd2; a_we = 1'b1; b_we = 1'b1;
        step(1); a_we = 1'b0; b_we = 1'b0;
        a_force = 1'b1; b_force = 1'b1; step(1); a_force = 1'b0; b_force = 1'b0;
        a_run = 1'b1; b_run = 1'b1;
        for (int i = 0; i < 11; i++) begin
            step(1);
            chk("R8 chained count", 32'(b_count), 32'(eb[i]));
            chk("R8 first timer underflow", 32'(a_uf),
                (i == 2 || i == 5 || i == 8) ? 32'd1 : 32'd0);
            chk("R8 chained underflow", 32'(b_uf), (i == 10) ? 32'd1 : 32'd0);
        end
        a_run = 1'b0; b_run = 1'b0; step(2);
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_clock_mode();
        t_stop();
        t_pin_mode();
        t_chain();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule